// File: doc/BRIEF.md
# CPU control/status register unit

This block executes the privileged control/status register instructions of a 64-bit core. A decoded 32-bit instruction word arrives together with the current privilege level, the instruction address and the two source register values. The block then performs a read, a full write or a masked exchange on one of its internal control registers. For the destination register it returns the value the control register held before the operation.

Each register has its own write rules. The exception-status register takes only its two software interrupt bits. The address-space-ID register takes only its ID field and asks for a TLB flush when that field changes. A write to the timer-clear register pulses a clear of the pending timer interrupt. The page-directory register is read-only: its read value is picked from two base registers by the top bit of the current faulting address. Writes that change the execution mode, the extension enables or the address-space ID ask the pipeline to refetch from the next instruction.

TLB contents, the timer and the rest of the pipeline stay outside the block. It reaches them only through output strobes and status inputs.

Top module: `csr_unit`

## Requirements
- R1: An instruction is accepted when `valid_i` is high and `instr_i[31:24]` is 8'h04. The register number is in bits [23:10], the mask register index `rj` in bits [9:5] and the destination index `rd` in bits [4:0]. `rj`=0 selects read, `rj`=1 selects write, and any other `rj` selects exchange. When the top byte is anything else, no result is produced. `rd_idx_o` echoes `rd`.
- R2: `ready_o` is always high. The results, `done_o` and every strobe appear in the cycle after acceptance and last exactly one cycle.
- R3: At user privilege (`priv_i`=2'd3), all three operations raise `exc_o`. They write no register, set `rd_we_o` low and raise no other strobe.
- R4: A register number outside the defined map reads as 0. A write or exchange to such a number changes nothing, raises no exception and returns 0.
- R5: The following numbers are read-only: misc 0x003, bad-instruction 0x008, page directory 0x01B, core ID 0x020, configuration words 0x021 to 0x023, and timer value 0x042. A write or exchange to any of them raises `exc_o` and changes nothing. A read works normally: the timer value reads `timer_val_i`, and the core ID reads the `CORE_ID` parameter.
- R6: A write stores `rd_val_i` and returns the previous value. The scratch registers at 0x030 upward (`NUM_SCRATCH` of them) are plain storage.
- R7: An exchange stores `(rd_val_i & rj_val_i) | (old & ~rj_val_i)` and returns the old value.
- R8: In the exception-status register (0x005), only bits [1:0] are writable. Bits [12:2] show `hw_irq_i` delayed by one cycle, and all higher bits read 0.
- R9: In the address-space-ID register (0x018), only bits [9:0] are stored. `tlb_flush_o` is raised only when a completed write or exchange changes that field.
- R10: Writing the timer-clear register (0x044) with bit 0 set raises `timer_clr_o`. With bit 0 clear, no strobe is raised. The register always reads 0.
- R11: A read of the page directory (0x01B) first picks a faulting address. It uses the refill bad address (0x089) when bit 0 of the refill return register (0x08A) is 1, and the bad address (0x007) otherwise. The read then returns the high base (0x01A) if bit 63 of that address is 1, and the low base (0x019) otherwise.
- R12: A completed write or exchange to mode (0x000), extension enable (0x002) or address-space ID (0x018) raises `flush_o`, with `redirect_pc_o` equal to `pc_i`+4. Writes to other registers raise no flush.
- R13: After reset, mode (0x000) reads `MODE_RST` (default 64'h8), and every other writable register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present |
| ready_o | output | 1 | Accepting instructions (always high) |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 64 | Address of the instruction |
| priv_i | input | 2 | Current privilege level, 3 = user |
| rd_val_i | input | 64 | Value of source register rd |
| rj_val_i | input | 64 | Value of mask register rj |
| timer_val_i | input | 64 | Live timer value |
| hw_irq_i | input | 11 | Hardware interrupt lines |
| done_o | output | 1 | Result valid, one cycle |
| rd_we_o | output | 1 | Destination register write enable |
| rd_idx_o | output | 5 | Destination register index |
| rd_wdata_o | output | 64 | Old register value for rd |
| exc_o | output | 1 | Exception (privilege or read-only) |
| flush_o | output | 1 | Flush and refetch request |
| redirect_pc_o | output | 64 | Refetch address |
| tlb_flush_o | output | 1 | TLB flush request |
| timer_clr_o | output | 1 | Clear pending timer interrupt |

## Verification
The bench checks the masked exchange formula against known values on both sides of the mask. A design that swapped the mask polarity or returned the new value instead of the old one would fail the readback. It rewrites the address-space ID with an unchanged field but different upper bits, which catches a flush decision that compares the whole source word. It writes all ones to the exception-status register while hardware lines are active, which exposes a write that clobbers the hardware bits. It steers the page-directory read through both address sources and both halves, and it issues writes to read-only and undefined numbers and at user privilege, confirming that state is untouched and only the right strobes fire.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int XLEN    = 64;
  localparam int CSR_AW  = 14;
  localparam int ASID_W  = 10;
  localparam int HWIRQ_W = 11;
  localparam int NUM_CFG = 3;

  localparam logic [7:0] CSR_OPC   = 8'h04;
  localparam logic [1:0] PRIV_USER = 2'd3;

  localparam logic [CSR_AW-1:0] A_MODE      = 14'h000;
  localparam logic [CSR_AW-1:0] A_PRV_SAVE  = 14'h001;
  localparam logic [CSR_AW-1:0] A_EXT_EN    = 14'h002;
  localparam logic [CSR_AW-1:0] A_MISC      = 14'h003;
  localparam logic [CSR_AW-1:0] A_EXC_STAT  = 14'h005;
  localparam logic [CSR_AW-1:0] A_BAD_VA    = 14'h007;
  localparam logic [CSR_AW-1:0] A_BAD_INSTR = 14'h008;
  localparam logic [CSR_AW-1:0] A_ASID      = 14'h018;
  localparam logic [CSR_AW-1:0] A_PGD_LO    = 14'h019;
  localparam logic [CSR_AW-1:0] A_PGD_HI    = 14'h01A;
  localparam logic [CSR_AW-1:0] A_PGD       = 14'h01B;
  localparam logic [CSR_AW-1:0] A_CORE_ID   = 14'h020;
  localparam logic [CSR_AW-1:0] A_CFG0      = 14'h021;
  localparam logic [CSR_AW-1:0] A_CFG1      = 14'h022;
  localparam logic [CSR_AW-1:0] A_CFG2      = 14'h023;
  localparam logic [CSR_AW-1:0] A_SCR_BASE  = 14'h030;
  localparam logic [CSR_AW-1:0] A_TMR_VAL   = 14'h042;
  localparam logic [CSR_AW-1:0] A_TMR_CLR   = 14'h044;
  localparam logic [CSR_AW-1:0] A_RF_BADV   = 14'h089;
  localparam logic [CSR_AW-1:0] A_RF_ERA    = 14'h08A;

  typedef enum logic [1:0] {OP_RD, OP_WR, OP_XCHG} csr_op_e;

  typedef struct packed {
    logic defined;
    logic read_only;
    logic exit_on_wr;
  } csr_attr_t;
endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_pkg::*;
#(
  parameter int NUM_SCRATCH = 16
) (
  input  logic [31:0]       instr_i,
  output logic              is_csr_o,
  output csr_op_e           op_o,
  output logic [CSR_AW-1:0] num_o,
  output logic [4:0]        rd_o,
  output csr_attr_t         attr_o
);
  localparam logic [CSR_AW-1:0] SCR_END = A_SCR_BASE + CSR_AW'(NUM_SCRATCH);

  logic [4:0] rj;
  logic       in_scratch;

  assign is_csr_o = (instr_i[31:24] == CSR_OPC);
  assign num_o    = instr_i[23:10];
  assign rj       = instr_i[9:5];
  assign rd_o     = instr_i[4:0];

  always_comb begin
    if (rj == 5'd0)      op_o = OP_RD;
    else if (rj == 5'd1) op_o = OP_WR;
    else                 op_o = OP_XCHG;
  end

  assign in_scratch = (num_o >= A_SCR_BASE) && (num_o < SCR_END);

  always_comb begin
    attr_o = '{defined: 1'b1, read_only: 1'b0, exit_on_wr: 1'b0};
    case (num_o)
      A_MODE, A_EXT_EN, A_ASID: attr_o.exit_on_wr = 1'b1;
      A_PRV_SAVE, A_EXC_STAT, A_BAD_VA, A_PGD_LO, A_PGD_HI,
      A_TMR_CLR, A_RF_BADV, A_RF_ERA: attr_o.read_only = 1'b0;
      A_MISC, A_BAD_INSTR, A_PGD, A_CORE_ID, A_CFG0, A_CFG1, A_CFG2,
      A_TMR_VAL: attr_o.read_only = 1'b1;
      default: attr_o.defined = in_scratch;
    endcase
  end
endmodule

// File: rtl/csr_file.sv
module csr_file
  import csr_pkg::*;
#(
  parameter int                          NUM_SCRATCH = 16,
  parameter logic [XLEN-1:0]             CORE_ID     = '0,
  parameter logic [XLEN-1:0]             MODE_RST    = 64'h8,
  parameter logic [NUM_CFG-1:0][XLEN-1:0] CFG_WORDS  = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CSR_AW-1:0]  num_i,
  input  logic               wr_en_i,
  input  logic [XLEN-1:0]    wdata_i,
  input  logic [XLEN-1:0]    timer_val_i,
  input  logic [HWIRQ_W-1:0] hw_irq_i,
  output logic [XLEN-1:0]    rdata_o,
  output logic               asid_chg_o,
  output logic               tmr_clr_o
);
  logic [XLEN-1:0]    mode_q, prv_save_q, ext_en_q, bad_va_q;
  logic [XLEN-1:0]    pgd_lo_q, pgd_hi_q, rf_badv_q, rf_era_q;
  logic [ASID_W-1:0]  asid_q;
  logic [1:0]         sw_irq_q;
  logic [HWIRQ_W-1:0] hw_irq_q;
  logic [XLEN-1:0]    scratch_q [NUM_SCRATCH];
  logic [XLEN-1:0]    fault_va;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_RST;
      prv_save_q <= '0;
      ext_en_q   <= '0;
      bad_va_q   <= '0;
      pgd_lo_q   <= '0;
      pgd_hi_q   <= '0;
      rf_badv_q  <= '0;
      rf_era_q   <= '0;
      asid_q     <= '0;
      sw_irq_q   <= '0;
      hw_irq_q   <= '0;
    end else begin
      hw_irq_q <= hw_irq_i;
      if (wr_en_i) begin
        case (num_i)
          A_MODE:     mode_q     <= wdata_i;
          A_PRV_SAVE: prv_save_q <= wdata_i;
          A_EXT_EN:   ext_en_q   <= wdata_i;
          A_BAD_VA:   bad_va_q   <= wdata_i;
          A_PGD_LO:   pgd_lo_q   <= wdata_i;
          A_PGD_HI:   pgd_hi_q   <= wdata_i;
          A_RF_BADV:  rf_badv_q  <= wdata_i;
          A_RF_ERA:   rf_era_q   <= wdata_i;
          A_ASID:     asid_q     <= wdata_i[ASID_W-1:0];
          A_EXC_STAT: sw_irq_q   <= wdata_i[1:0];
          default:    ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_SCRATCH; g++) begin : g_scratch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) scratch_q[g] <= '0;
      else if (wr_en_i && num_i == A_SCR_BASE + CSR_AW'(g)) scratch_q[g] <= wdata_i;
    end
  end

  // page-directory source: refill context wins when its flag bit is set
  assign fault_va = rf_era_q[0] ? rf_badv_q : bad_va_q;

  always_comb begin
    rdata_o = '0;
    case (num_i)
      A_MODE:     rdata_o = mode_q;
      A_PRV_SAVE: rdata_o = prv_save_q;
      A_EXT_EN:   rdata_o = ext_en_q;
      A_BAD_VA:   rdata_o = bad_va_q;
      A_PGD_LO:   rdata_o = pgd_lo_q;
      A_PGD_HI:   rdata_o = pgd_hi_q;
      A_RF_BADV:  rdata_o = rf_badv_q;
      A_RF_ERA:   rdata_o = rf_era_q;
      A_ASID:     rdata_o = XLEN'(asid_q);
      A_EXC_STAT: rdata_o = XLEN'({hw_irq_q, sw_irq_q});
      A_PGD:      rdata_o = fault_va[XLEN-1] ? pgd_hi_q : pgd_lo_q;
      A_CORE_ID:  rdata_o = CORE_ID;
      A_CFG0:     rdata_o = CFG_WORDS[0];
      A_CFG1:     rdata_o = CFG_WORDS[1];
      A_CFG2:     rdata_o = CFG_WORDS[2];
      A_TMR_VAL:  rdata_o = timer_val_i;
      default: begin
        for (int k = 0; k < NUM_SCRATCH; k++)
          if (num_i == A_SCR_BASE + CSR_AW'(k)) rdata_o = scratch_q[k];
      end
    endcase
  end

  assign asid_chg_o = wr_en_i && (num_i == A_ASID) && (wdata_i[ASID_W-1:0] != asid_q);
  assign tmr_clr_o  = wr_en_i && (num_i == A_TMR_CLR) && wdata_i[0];

  p_asid_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asid_chg_o |=> asid_q != $past(asid_q));

  p_sw_irq_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && num_i == A_EXC_STAT) |=> sw_irq_q == $past(wdata_i[1:0]));
endmodule

// File: rtl/csr_unit.sv
module csr_unit
  import csr_pkg::*;
#(
  parameter int                           NUM_SCRATCH = 16,
  parameter logic [63:0]                  CORE_ID     = '0,
  parameter logic [63:0]                  MODE_RST    = 64'h8,
  parameter logic [NUM_CFG-1:0][63:0]     CFG_WORDS   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  output logic         ready_o,
  input  logic [31:0]  instr_i,
  input  logic [63:0]  pc_i,
  input  logic [1:0]   priv_i,
  input  logic [63:0]  rd_val_i,
  input  logic [63:0]  rj_val_i,
  input  logic [63:0]  timer_val_i,
  input  logic [10:0]  hw_irq_i,
  output logic         done_o,
  output logic         rd_we_o,
  output logic [4:0]   rd_idx_o,
  output logic [63:0]  rd_wdata_o,
  output logic         exc_o,
  output logic         flush_o,
  output logic [63:0]  redirect_pc_o,
  output logic         tlb_flush_o,
  output logic         timer_clr_o
);
  logic              is_csr, fire, user, is_wr, exc, wr_en;
  csr_op_e           op;
  logic [CSR_AW-1:0] num;
  logic [4:0]        rd;
  csr_attr_t         attr;
  logic [XLEN-1:0]   rdata, old_val, new_val;
  logic              asid_chg, tmr_clr;

  csr_decode #(.NUM_SCRATCH(NUM_SCRATCH)) u_dec (
    .instr_i (instr_i),
    .is_csr_o(is_csr),
    .op_o    (op),
    .num_o   (num),
    .rd_o    (rd),
    .attr_o  (attr)
  );

  assign ready_o = 1'b1;
  assign fire    = valid_i && is_csr;
  assign user    = (priv_i == PRIV_USER);
  assign is_wr   = (op != OP_RD);
  assign exc     = user || (attr.defined && attr.read_only && is_wr);
  assign wr_en   = fire && !exc && attr.defined && is_wr;
  assign old_val = attr.defined ? rdata : '0;
  assign new_val = (op == OP_WR) ? rd_val_i : ((rd_val_i & rj_val_i) | (rdata & ~rj_val_i));

  csr_file #(
    .NUM_SCRATCH(NUM_SCRATCH),
    .CORE_ID    (CORE_ID),
    .MODE_RST   (MODE_RST),
    .CFG_WORDS  (CFG_WORDS)
  ) u_file (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .num_i      (num),
    .wr_en_i    (wr_en),
    .wdata_i    (new_val),
    .timer_val_i(timer_val_i),
    .hw_irq_i   (hw_irq_i),
    .rdata_o    (rdata),
    .asid_chg_o (asid_chg),
    .tmr_clr_o  (tmr_clr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o        <= 1'b0;
      rd_we_o       <= 1'b0;
      exc_o         <= 1'b0;
      flush_o       <= 1'b0;
      tlb_flush_o   <= 1'b0;
      timer_clr_o   <= 1'b0;
      rd_idx_o      <= '0;
      rd_wdata_o    <= '0;
      redirect_pc_o <= '0;
    end else begin
      done_o      <= fire;
      rd_we_o     <= fire && !exc;
      exc_o       <= fire && exc;
      flush_o     <= wr_en && attr.exit_on_wr;
      tlb_flush_o <= asid_chg;
      timer_clr_o <= tmr_clr;
      if (fire) begin
        rd_idx_o      <= rd;
        rd_wdata_o    <= exc ? '0 : old_val;
        redirect_pc_o <= pc_i + 64'd4;
      end
    end
  end

  p_user_trap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && user) |=> (exc_o && !rd_we_o && !flush_o && !tlb_flush_o && !timer_clr_o));

  p_undef_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !user && !attr.defined) |=> (rd_wdata_o == '0 && !exc_o && rd_we_o));

  p_ro_trap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !user && attr.defined && attr.read_only && is_wr) |=> exc_o);

  p_one_shot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> !done_o);

  p_tclr_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_clr_o |-> (done_o && !exc_o));

  p_flush_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (rd_we_o && !exc_o));
endmodule

// File: tb/csr_unit_tb.sv
module csr_unit_tb;
  localparam logic [63:0] CID = 64'h2A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        ready;
  logic [31:0] instr = '0;
  logic [63:0] pc = 64'h9000_1000;
  logic [1:0]  priv = 2'd0;
  logic [63:0] rd_val = '0, rj_val = '0, tval = 64'hABCD_0123;
  logic [10:0] hw_irq = '0;
  logic        done, rd_we, exc, flush, tlbf, tclr;
  logic [4:0]  rd_idx;
  logic [63:0] rd_wdata, rpc;

  int checks = 0;
  int errors = 0;

  logic        r_done, r_we, r_exc, r_flush, r_tlb, r_tclr;
  logic [4:0]  r_idx;
  logic [63:0] r_data, r_pc;

  always #10 clk = ~clk;

  csr_unit #(.CORE_ID(CID)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ready_o(ready),
    .instr_i(instr), .pc_i(pc), .priv_i(priv), .rd_val_i(rd_val),
    .rj_val_i(rj_val), .timer_val_i(tval), .hw_irq_i(hw_irq),
    .done_o(done), .rd_we_o(rd_we), .rd_idx_o(rd_idx), .rd_wdata_o(rd_wdata),
    .exc_o(exc), .flush_o(flush), .redirect_pc_o(rpc),
    .tlb_flush_o(tlbf), .timer_clr_o(tclr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] opc, input logic [4:0] rj, input logic [13:0] num,
                       input logic [63:0] rdv, input logic [63:0] mask, input logic [1:0] pl);
    @(negedge clk);
    valid  = 1'b1;
    instr  = {opc, num, rj, 5'd7};
    rd_val = rdv;
    rj_val = mask;
    priv   = pl;
    @(negedge clk);
    valid = 1'b0;
    r_done = done; r_we = rd_we; r_exc = exc; r_flush = flush;
    r_tlb = tlbf; r_tclr = tclr; r_idx = rd_idx; r_data = rd_wdata; r_pc = rpc;
  endtask

  task automatic rd(input logic [13:0] num);
    issue(8'h04, 5'd0, num, '0, '0, 2'd0);
  endtask
  task automatic wr(input logic [13:0] num, input logic [63:0] v);
    issue(8'h04, 5'd1, num, v, '0, 2'd0);
  endtask

  task automatic t_reset;
    chk("R13 done idle", {63'd0, done}, 64'd0);
    rd(14'h000); chk("R13 mode reset", r_data, 64'h8);
    rd(14'h030); chk("R13 scratch reset", r_data, 64'd0);
    rd(14'h020); chk("R5 core id", r_data, CID);
    chk("R2 ready", {63'd0, ready}, 64'd1);
  endtask

  task automatic t_write;
    wr(14'h033, 64'h1111_2222_3333_4444);
    chk("R6 first old", r_data, 64'd0);
    chk("R1 rd idx", {59'd0, r_idx}, 64'd7);
    chk("R1 we", {63'd0, r_we}, 64'd1);
    wr(14'h033, 64'h5555);
    chk("R6 second old", r_data, 64'h1111_2222_3333_4444);
    rd(14'h033); chk("R6 readback", r_data, 64'h5555);
    @(negedge clk);
    chk("R2 strobe gone", {63'd0, done}, 64'd0);
  endtask

  task automatic t_xchg;
    logic [63:0] o, v, m;
    o = 64'hFF00_FF00_FF00_FF00; v = 64'h1234_5678_9ABC_DEF0; m = 64'h0000_FFFF_0000_FFFF;
    wr(14'h034, o);
    issue(8'h04, 5'd9, 14'h034, v, m, 2'd0);
    chk("R7 old", r_data, o);
    rd(14'h034); chk("R7 merged", r_data, (v & m) | (o & ~m));
  endtask

  task automatic t_user;
    wr(14'h035, 64'hAA);
    issue(8'h04, 5'd1, 14'h035, 64'hBB, '0, 2'd3);
    chk("R3 exc", {63'd0, r_exc}, 64'd1);
    chk("R3 no we", {63'd0, r_we}, 64'd0);
    issue(8'h04, 5'd1, 14'h000, 64'hBB, '0, 2'd3);
    chk("R3 no flush", {63'd0, r_flush}, 64'd0);
    rd(14'h035); chk("R3 unchanged", r_data, 64'hAA);
  endtask

  task automatic t_undef;
    wr(14'h3FF, 64'hDEAD);
    chk("R4 write old zero", r_data, 64'd0);
    chk("R4 no exc", {63'd0, r_exc}, 64'd0);
    issue(8'h04, 5'd3, 14'h3FF, 64'hFFFF, 64'hFFFF, 2'd0);
    chk("R4 xchg zero", r_data, 64'd0);
    rd(14'h3FF); chk("R4 read zero", r_data, 64'd0);
  endtask

  task automatic t_ro;
    wr(14'h020, 64'h77);
    chk("R5 ro trap", {63'd0, r_exc}, 64'd1);
    rd(14'h020); chk("R5 ro unchanged", r_data, CID);
    issue(8'h04, 5'd4, 14'h01B, 64'h1, 64'h1, 2'd0);
    chk("R5 pgd xchg trap", {63'd0, r_exc}, 64'd1);
    rd(14'h042); chk("R5 timer value", r_data, tval);
  endtask

  task automatic t_estat;
    @(negedge clk); hw_irq = 11'h5A5;
    wr(14'h005, '1);
    rd(14'h005); chk("R8 status", r_data, (64'h5A5 << 2) | 64'h3);
    issue(8'h04, 5'd2, 14'h005, 64'h0, 64'h1, 2'd0);
    rd(14'h005); chk("R8 xchg bit0", r_data, (64'h5A5 << 2) | 64'h2);
  endtask

  task automatic t_asid;
    pc = 64'h9000_2000;
    wr(14'h018, 64'h12345);
    chk("R9 flush on change", {63'd0, r_tlb}, 64'd1);
    chk("R12 asid exit", {63'd0, r_flush}, 64'd1);
    chk("R12 redirect", r_pc, 64'h9000_2004);
    wr(14'h018, 64'hFC345);
    chk("R9 same field no flush", {63'd0, r_tlb}, 64'd0);
    chk("R9 old field", r_data, 64'h345);
    rd(14'h018); chk("R9 stored field", r_data, 64'h345);
  endtask

  task automatic t_tclr;
    wr(14'h044, 64'h1);
    chk("R10 clear pulse", {63'd0, r_tclr}, 64'd1);
    chk("R10 old zero", r_data, 64'd0);
    wr(14'h044, 64'h2);
    chk("R10 no pulse", {63'd0, r_tclr}, 64'd0);
    rd(14'h044); chk("R10 reads zero", r_data, 64'd0);
  endtask

  task automatic t_pgd;
    wr(14'h019, 64'h1000); wr(14'h01A, 64'h2000);
    wr(14'h007, 64'h8000_0000_0000_0000); wr(14'h08A, 64'h0);
    rd(14'h01B); chk("R11 badva hi", r_data, 64'h2000);
    wr(14'h089, 64'h0000_0000_0000_0040); wr(14'h08A, 64'h1);
    rd(14'h01B); chk("R11 refill lo", r_data, 64'h1000);
  endtask

  task automatic t_misc;
    issue(8'h05, 5'd1, 14'h036, 64'h99, '0, 2'd0);
    chk("R1 bad opcode no done", {63'd0, r_done}, 64'd0);
    rd(14'h036); chk("R1 bad opcode no write", r_data, 64'd0);
    pc = 64'h9000_3000;
    wr(14'h002, 64'h3);
    chk("R12 ext exit", {63'd0, r_flush}, 64'd1);
    chk("R12 ext redirect", r_pc, 64'h9000_3004);
    wr(14'h037, 64'h3);
    chk("R12 plain no exit", {63'd0, r_flush}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_xchg();
    t_user();
    t_undef();
    t_ro();
    t_estat();
    t_asid();
    t_tclr();
    t_pgd();
    t_misc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule